// File: doc/BRIEF.md
# UART Receive DMA Engine

This block takes bytes from a UART receiver, modelled as a byte stream with per-byte line-error flags, and stores them into memory without processor help. Software programs a destination base address and a byte count. It then enables the interrupts it wants and sets an enable bit. The engine writes each good byte to the next address through a valid/ready write port.

The transfer ends in one of three ways:
- The programmed count is reached. The engine raises a done event.
- A byte arrives with any line-error flag. The byte is dropped and the engine raises an error event, with one status bit per error kind.
- Software clears the enable bit. This is an abort.

In all three cases the enable bit drops by itself once no memory write is outstanding. Software polls the enable bit before reprogramming. A live current-address register shows the next write address, so the number of bytes moved is that value minus the base.

Registers sit on a simple word-indexed port. Writes take effect at the clock edge where `reg_we` is high. Read data is registered: it reflects the `reg_addr` present at the previous edge.

Register map (word index):

| Index | Contents |
|---|---|
| 0 | Base address |
| 1 | Size |
| 2 | Control (bit 0 = enable) |
| 3 | Interrupt enable (bit 0 = done, bit 1 = error) |
| 4 | Status |
| 5 | Current address (read only) |

Top module: `uart_rxdma`

## Requirements
- R1: After reset every register reads zero, and `irq`, `mem_valid` and `rx_ready` are low.
- R2: Writing 1 to control bit 0 (index 2) with an aligned base starts a transfer. Bit 0 reads 1 while the transfer is active and clears by itself when it ends. While idle, `mem_valid` and `rx_ready` are low.
- R3: A start is rejected when the base has any of its low `ALIGN_BITS` bits set. Enable stays 0, no write occurs, and status and current address are unchanged.
- R4: Each error-free byte is written in arrival order to consecutive addresses from the base. A pending write holds `mem_valid`, `mem_addr` and `mem_data` until `mem_ready`. The current address advances by one only on an accepted write.
- R5: After SIZE bytes are accepted, status bit 0 (done) is set, enable clears and the current address equals base plus SIZE.
- R6: A start with SIZE zero sets done with no memory write, leaving the current address at the base.
- R7: A byte with a nonzero `rx_err` is not written. In `rx_err`, bit 0 is overrun, bit 1 parity, bit 2 framing and bit 3 break. Such a byte stops the transfer, clears enable and sets status bit 1 (error). It also copies `rx_err` into status bits 2 to 5. Done is not set.
- R8: Writing 0 to enable during a transfer stops taking bytes. Enable stays 1 until a pending write is accepted, and then clears. No status bit is set, and the current address shows the bytes written.
- R9: Writing the status register (index 4) clears each bit written as 1 and keeps the others.
- R10: `irq` is high, one cycle after the state changes, exactly when (done and interrupt-enable bit 0) or (error and interrupt-enable bit 1).
- R11: `rx_ready` is high only while a transfer is active, no write is pending and no abort is being written, so no byte is consumed without being written or flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous `reg_addr` |
| irq | output | 1 | Interrupt request |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_err | input | 4 | Line-error flags of the byte |
| rx_ready | output | 1 | Byte accepted when high with `rx_valid` |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | AW | Memory write byte address |
| mem_data | output | 8 | Memory write byte |
| mem_ready | input | 1 | Memory accepts the write |

## Verification
The bench builds the block with its defaults: 32-bit addresses, a 16-bit size field and four alignment bits. A base ending in hex 4 is therefore a rejected start. Transfer lengths stay short, so every run finishes in tens of cycles, while the wide size counter still exercises the count-of-one and count-of-zero edges. The memory model can accept every cycle, accept one cycle in four, or refuse entirely. Refusing entirely pins a write pending, which makes the drain phase of an abort observable at the enable bit.

// File: rtl/uart_rxdma_pkg.sv
package uart_rxdma_pkg;
  localparam int REG_W = 32;
  localparam int NERR  = 4;
  localparam int SW    = 2 + NERR;

  localparam logic [2:0] OFS_BASE = 3'd0;
  localparam logic [2:0] OFS_SIZE = 3'd1;
  localparam logic [2:0] OFS_CTRL = 3'd2;
  localparam logic [2:0] OFS_IEN  = 3'd3;
  localparam logic [2:0] OFS_STAT = 3'd4;
  localparam logic [2:0] OFS_CUR  = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} xfer_state_e;

  // One-cycle event from the transfer engine to the status register
  typedef struct packed {
    logic [NERR-1:0] kind;
    logic            err;
    logic            done;
  } evt_t;
endpackage

// File: rtl/uart_rxdma_ctrl.sv
module uart_rxdma_ctrl
  import uart_rxdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            abort,
  input  logic [AW-1:0]   base,
  input  logic [CW-1:0]   size,
  input  logic            rx_valid,
  input  logic [DW-1:0]   rx_data,
  input  logic [NERR-1:0] rx_err,
  output logic            rx_ready,
  output logic            mem_valid,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_data,
  input  logic            mem_ready,
  output logic            busy,
  output logic [AW-1:0]   cur_addr,
  output evt_t            evt
);
  xfer_state_e   st;
  logic [AW-1:0] cur;
  logic [CW-1:0] left;
  logic          mv;
  logic [AW-1:0] ma;
  logic [DW-1:0] md;
  evt_t          ev;
  logic          accept, take, last;

  assign accept   = mv && mem_ready;
  assign rx_ready = (st == ST_RUN) && !mv && !abort;
  assign take     = rx_valid && rx_ready;
  assign last     = (left == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      cur  <= '0;
      left <= '0;
      mv   <= 1'b0;
      ma   <= '0;
      md   <= '0;
      ev   <= '0;
    end else begin
      ev <= '0;
      if (accept) begin
        mv   <= 1'b0;
        cur  <= cur + AW'(1);
        left <= left - CW'(1);
      end
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            cur  <= base;
            left <= size;
            if (size == '0) ev.done <= 1'b1;
            else            st      <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (accept && last) begin
            ev.done <= 1'b1;
            st      <= ST_IDLE;
          end else if (abort) begin
            st <= (mv && !accept) ? ST_DRAIN : ST_IDLE;
          end else if (take) begin
            if (|rx_err) begin
              ev.err  <= 1'b1;
              ev.kind <= rx_err;
              st      <= ST_IDLE;
            end else begin
              mv <= 1'b1;
              ma <= cur;
              md <= rx_data;
            end
          end
        end
        ST_DRAIN: begin
          if (accept) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_valid = mv;
  assign mem_addr  = ma;
  assign mem_data  = md;
  assign busy      = (st != ST_IDLE);
  assign cur_addr  = cur;
  assign evt       = ev;
endmodule

// File: rtl/uart_rxdma_regs.sv
module uart_rxdma_regs
  import uart_rxdma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int ALIGN_BITS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq,
  input  logic             busy,
  input  logic [AW-1:0]    cur_addr,
  input  evt_t             evt,
  output logic             start,
  output logic             abort,
  output logic [AW-1:0]    base,
  output logic [CW-1:0]    size
);
  logic [AW-1:0]    base_q;
  logic [CW-1:0]    size_q;
  logic [1:0]       ien_q;
  logic [SW-1:0]    stat_q;
  logic [SW-1:0]    clr_mask, set_mask;
  logic [REG_W-1:0] rd_mux;
  logic             ctrl_wr, aligned;

  assign ctrl_wr  = reg_we && (reg_addr == OFS_CTRL);
  assign aligned  = (base_q[ALIGN_BITS-1:0] == '0);
  assign start    = ctrl_wr && reg_wdata[0] && !busy && aligned;
  assign abort    = ctrl_wr && !reg_wdata[0] && busy;
  assign clr_mask = (reg_we && reg_addr == OFS_STAT) ? reg_wdata[SW-1:0] : '0;
  assign set_mask = evt;

  always_comb begin
    unique case (reg_addr)
      OFS_BASE: rd_mux = REG_W'(base_q);
      OFS_SIZE: rd_mux = REG_W'(size_q);
      OFS_CTRL: rd_mux = REG_W'(busy);
      OFS_IEN:  rd_mux = REG_W'(ien_q);
      OFS_STAT: rd_mux = REG_W'(stat_q);
      OFS_CUR:  rd_mux = REG_W'(cur_addr);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      size_q    <= '0;
      ien_q     <= '0;
      stat_q    <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_we) begin
        unique case (reg_addr)
          OFS_BASE: base_q <= reg_wdata[AW-1:0];
          OFS_SIZE: size_q <= reg_wdata[CW-1:0];
          OFS_IEN:  ien_q  <= reg_wdata[1:0];
          default: ;
        endcase
      end
      // a new event wins over a clear in the same cycle
      stat_q    <= (stat_q & ~clr_mask) | set_mask;
      irq       <= |(stat_q[1:0] & ien_q);
      reg_rdata <= rd_mux;
    end
  end

  assign base = base_q;
  assign size = size_q;
endmodule

// File: rtl/uart_rxdma.sv
module uart_rxdma
  import uart_rxdma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int ALIGN_BITS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic [NERR-1:0]  rx_err,
  output logic             rx_ready,
  output logic             mem_valid,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_data,
  input  logic             mem_ready
);
  logic          start, abort, busy;
  logic [AW-1:0] base, cur_addr;
  logic [CW-1:0] size;
  evt_t          evt;

  uart_rxdma_regs #(.AW(AW), .CW(CW), .ALIGN_BITS(ALIGN_BITS)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .busy(busy), .cur_addr(cur_addr), .evt(evt),
    .start(start), .abort(abort), .base(base), .size(size)
  );

  uart_rxdma_ctrl #(.AW(AW), .CW(CW), .DW(8)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .abort(abort),
    .base(base), .size(size),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err), .rx_ready(rx_ready),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready),
    .busy(busy), .cur_addr(cur_addr), .evt(evt)
  );
endmodule

// File: rtl/uart_rxdma_chk.sv
module uart_rxdma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_data,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [3:0]    rx_err,
  input logic          busy,
  input logic [AW-1:0] cur_addr
);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_ready |=> cur_addr == $past(mem_addr) + AW'(1));

  p_addr_r4: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> mem_addr == cur_addr);

  p_gate_r11: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> busy && !mem_valid);

  p_errdrop_r7: assert property (@(posedge clk) disable iff (rst)
    rx_valid && rx_ready && (rx_err != 4'd0) |=> !mem_valid && !busy);

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_valid && !rx_ready);
endmodule

bind uart_rxdma uart_rxdma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_err(rx_err), .busy(busy), .cur_addr(cur_addr)
);

// File: tb/uart_rxdma_test.sv
module uart_rxdma_test;
  localparam logic [2:0] A_BASE = 3'd0, A_SIZE = 3'd1, A_CTRL = 3'd2,
                         A_IEN = 3'd3, A_STAT = 3'd4, A_CUR = 3'd5;

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] size;
    logic [7:0]  seed;
    logic [7:0]  errat;
    logic [3:0]  code;
    logic [1:0]  rdy;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 16'd5, 8'h10, 8'hFF, 4'h0, 2'd0},
    '{32'h0000_2040, 16'd9, 8'hA0, 8'hFF, 4'h0, 2'd1},
    '{32'h0000_3000, 16'd8, 8'h33, 8'd3,  4'h1, 2'd0},
    '{32'h0000_3010, 16'd6, 8'h40, 8'd0,  4'h8, 2'd1},
    '{32'h0000_4000, 16'd7, 8'h77, 8'd5,  4'h6, 2'd0},
    '{32'h0000_5000, 16'd1, 8'hC5, 8'hFF, 4'h0, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq, rx_valid, rx_ready, mem_valid, mem_ready;
  logic [7:0]  rx_data, mem_data;
  logic [3:0]  rx_err;
  logic [31:0] mem_addr;

  always #5 clk = ~clk;

  // byte source
  logic       src_on = 1'b0, src_clr = 1'b0;
  logic [7:0] src_seed = 8'd0, src_errat = 8'hFF;
  logic [3:0] src_code = 4'd0;
  int         src_idx;
  always @(posedge clk) begin
    if (src_clr) src_idx <= 0;
    else if (rx_valid && rx_ready) src_idx <= src_idx + 1;
  end
  assign rx_valid = src_on;
  assign rx_data  = src_seed + src_idx[7:0];
  assign rx_err   = (src_idx == int'(src_errat)) ? src_code : 4'd0;

  // memory sink
  logic [1:0]  rdy_mode = 2'd0;
  logic [1:0]  cyc;
  logic [31:0] tb_base = 32'd0;
  logic [7:0]  sink [64];
  int          sink_cnt;
  logic        order_bad;
  always @(posedge clk) begin
    if (rst) cyc <= 2'd0;
    else     cyc <= cyc + 2'd1;
  end
  assign mem_ready = (rdy_mode == 2'd0) ? 1'b1 :
                     (rdy_mode == 2'd1) ? (cyc == 2'd3) : 1'b0;
  always @(posedge clk) begin
    if (src_clr) begin
      sink_cnt  <= 0;
      order_bad <= 1'b0;
    end else if (mem_valid && mem_ready) begin
      sink[(mem_addr - tb_base) & 32'd63] <= mem_data;
      sink_cnt <= sink_cnt + 1;
      if (mem_addr != tb_base + 32'(sink_cnt)) order_bad <= 1'b1;
    end
  end

  uart_rxdma uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err), .rx_ready(rx_ready),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(A_CTRL, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  task automatic setup(input logic [31:0] b, input logic [7:0] seed,
                       input logic [7:0] errat, input logic [3:0] code,
                       input logic [1:0] rdy);
    @(negedge clk);
    tb_base = b; src_seed = seed; src_errat = errat; src_code = code;
    rdy_mode = rdy; src_clr = 1'b1;
    @(negedge clk);
    src_clr = 1'b0;
  endtask

  task automatic data_check(input string req, input logic [7:0] seed, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++)
      if (sink[i] !== seed + 8'(i)) bad++;
    check(req, 32'(bad), 32'd0);
  endtask

  task automatic run_vec(input vec_t t);
    int n_exp;
    logic [31:0] s_exp, v;
    n_exp = (int'(t.errat) < int'(t.size)) ? int'(t.errat) : int'(t.size);
    s_exp = (n_exp < int'(t.size)) ? (32'h2 | (32'(t.code) << 2)) : 32'h1;
    setup(t.base, t.seed, t.errat, t.code, t.rdy);
    wr(A_STAT, 32'h3F);
    wr(A_BASE, t.base);
    wr(A_SIZE, 32'(t.size));
    wr(A_IEN, 32'h3);
    src_on = 1'b1;
    wr(A_CTRL, 32'h1);
    wait_idle();
    src_on = 1'b0;
    rd(A_CTRL, v); check("R2 enable self-clears", v, 32'h0);
    rd(A_CUR, v);  check("R5/R7 current address", v, t.base + 32'(n_exp));
    rd(A_STAT, v); check("R5/R7 status", v, s_exp);
    check("R4 write count", 32'(sink_cnt), 32'(n_exp));
    check("R4 address order", 32'(order_bad), 32'd0);
    data_check("R4 byte data", t.seed, n_exp);
    check("R10 irq with both enables", 32'(irq), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog all-requirements act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0;
    src_clr = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; src_clr = 1'b0;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R1 register reset", v, 32'h0);
    end
    check("R1 irq low", 32'(irq), 32'd0);
    check("R1 mem_valid low", 32'(mem_valid), 32'd0);
    check("R1 rx_ready low", 32'(rx_ready), 32'd0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R3 misaligned base
    setup(32'h0000_1004, 8'h01, 8'hFF, 4'h0, 2'd0);
    wr(A_STAT, 32'h3F);
    wr(A_BASE, 32'h0000_1004);
    wr(A_SIZE, 32'd4);
    src_on = 1'b1;
    wr(A_CTRL, 32'h1);
    idle(8);
    rd(A_CTRL, v); check("R3 enable stays 0", v, 32'h0);
    rd(A_STAT, v); check("R3 status unchanged", v, 32'h0);
    rd(A_CUR, v);  check("R3 current address unchanged", v, 32'h0000_5001);
    check("R3 no write", 32'(sink_cnt), 32'd0);
    check("R3 no byte taken", 32'(src_idx), 32'd0);
    src_on = 1'b0;

    // R8 abort with a pending write
    setup(32'h0000_7000, 8'h55, 8'hFF, 4'h0, 2'd0);
    wr(A_BASE, 32'h0000_7000);
    wr(A_SIZE, 32'd20);
    wr(A_IEN, 32'h0);
    src_on = 1'b1;
    wr(A_CTRL, 32'h1);
    idle(4);
    rdy_mode = 2'd2;
    idle(4);
    rd(A_CTRL, v); check("R2 enable reads 1 while active", v, 32'h1);
    wr(A_CTRL, 32'h0);
    idle(3);
    rd(A_CTRL, v); check("R8 enable held during drain", v, 32'h1);
    rdy_mode = 2'd0;
    idle(4);
    src_on = 1'b0;
    rd(A_CTRL, v); check("R8 enable clears after drain", v, 32'h0);
    rd(A_STAT, v); check("R8 no status on abort", v, 32'h0);
    c0 = 32'h0000_7000 + 32'(sink_cnt);
    rd(A_CUR, v);  check("R8 current address shows bytes written", v, c0);
    check("R8 partial transfer", 32'((sink_cnt > 0) && (sink_cnt < 20)), 32'd1);
    check("R11 no byte lost", 32'(src_idx), 32'(sink_cnt));
    data_check("R8 data before abort", 8'h55, sink_cnt);

    // R6 zero size
    setup(32'h0000_6000, 8'h00, 8'hFF, 4'h0, 2'd0);
    wr(A_BASE, 32'h0000_6000);
    wr(A_SIZE, 32'd0);
    src_on = 1'b1;
    wr(A_CTRL, 32'h1);
    idle(4);
    src_on = 1'b0;
    rd(A_STAT, v); check("R6 done on zero size", v, 32'h1);
    rd(A_CUR, v);  check("R6 address at base", v, 32'h0000_6000);
    rd(A_CTRL, v); check("R6 enable clear", v, 32'h0);
    check("R6 no write", 32'(sink_cnt), 32'd0);

    // error without clearing: status accumulates done plus framing error
    setup(32'h0000_8000, 8'h90, 8'd0, 4'h4, 2'd0);
    wr(A_BASE, 32'h0000_8000);
    wr(A_SIZE, 32'd3);
    src_on = 1'b1;
    wr(A_CTRL, 32'h1);
    wait_idle();
    src_on = 1'b0;
    rd(A_STAT, v); check("R7 framing error kept with done", v, 32'h13);
    check("R7 error byte not written", 32'(sink_cnt), 32'd0);

    // R10 masking
    wr(A_IEN, 32'h0); idle(2); check("R10 irq masked", 32'(irq), 32'd0);
    wr(A_IEN, 32'h2); idle(2); check("R10 irq on error", 32'(irq), 32'd1);
    wr(A_IEN, 32'h1); idle(2); check("R10 irq on done", 32'(irq), 32'd1);

    // R9 write-one-to-clear
    wr(A_STAT, 32'h02);
    rd(A_STAT, v); check("R9 partial clear", v, 32'h11);
    wr(A_IEN, 32'h2); idle(2); check("R10 irq drops with error cleared", 32'(irq), 32'd0);
    wr(A_STAT, 32'h11);
    rd(A_STAT, v); check("R9 full clear", v, 32'h0);
    wr(A_IEN, 32'h1); idle(2); check("R10 irq low after clear", 32'(irq), 32'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule